// File: doc/BRIEF.md
# Dual-Lane Half-Precision Multiplier

This block multiplies two pairs of 16-bit floating point numbers at the same time. Each 32-bit operand carries two packed lanes. Lane 0 sits in bits 15:0 and lane 1 sits in bits 31:16. Every lane uses a 1-bit sign, a 5-bit biased exponent (bias 15) and a 10-bit fraction with a hidden leading one. The block is meant to serve as the execution unit of a custom processor instruction. The core presents both operands with a valid strobe, and a packed 32-bit product comes back exactly two clock cycles later. The block never stalls.

Each lane works on its own and shares no state with the other lane. The first stage classifies the operands, adds the exponents with the bias removed, and forms the 11x11-bit significand product. The second stage normalises the product by at most one position, truncates the fraction, and handles overflow, underflow and special values. The block does not support subnormal numbers. An operand with a zero exponent field counts as zero, and a result too small for a normal number becomes zero. Any NaN result is the single quiet pattern 0x7E00.

Top module: `hmul2_top`

## Requirements
- R1: While reset is active, and until the first valid operand pair has gone through, `out_valid` is 0.
- R2: A pair presented with `in_valid`=1 on clock edge k produces `out_valid`=1 with its result after edge k+2. Back-to-back pairs give back-to-back results in the same order.
- R3: For two normal finite operands, the result sign is the XOR of the operand signs. The result exponent field is ea+eb-15. The fraction is bits 19:10 of the 22-bit significand product, with the low bits discarded (truncation).
- R4: When the 22-bit significand product has bit 21 set (value of 2.0 or more), the exponent is ea+eb-14 and the fraction is product bits 20:11.
- R5: An operand with exponent field 0 is treated as zero, whatever its fraction. Zero times a finite value gives zero, with the XOR sign.
- R6: A normalised exponent above 30 gives infinity (exponent 31, fraction 0) with the XOR sign.
- R7: A normalised exponent below 1 gives zero with the XOR sign. An exponent of exactly 1 or exactly 30 gives a normal result.
- R8: If either operand is a NaN (exponent 31, fraction nonzero), the lane result is 0x7E00.
- R9: Zero (including a flushed subnormal) times infinity, in either order, gives 0x7E00.
- R10: Infinity times a nonzero finite value or infinity gives infinity with the XOR sign.
- R11: Lane 0 uses bits 15:0 and lane 1 uses bits 31:16 of `a`, `b` and `y`. The value in one lane never changes the result of the other.
- R12: `y` keeps its last result in every cycle in which no new result is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| in_valid | input | 1 | Operand pair on `a`/`b` is valid this cycle |
| a | input | 32 | First operand, two packed half-precision lanes |
| b | input | 32 | Second operand, two packed half-precision lanes |
| out_valid | output | 1 | `y` carries a new result this cycle |
| y | output | 32 | Packed product, two half-precision lanes |

## Verification
The assertions assume that `in_valid` is never unknown after reset. They also assume that `a` and `b` only matter in cycles where `in_valid` is high. Operand registers load only under that strobe, and the hold and latency properties depend on it. The stimulus changes every input at the falling clock edge. It raises `in_valid` only once reset has been released and the internal synchroniser has settled. Idle gaps and back-to-back streams of operand pairs alternate, so that the hold behaviour and the ordering are both exercised inside these assumptions.

// File: rtl/hmul2_pkg.sv
package hmul2_pkg;
  localparam int EXP_W   = 5;
  localparam int FRAC_W  = 10;
  localparam int HALF_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int PROD_W  = 2 * SIG_W;
  localparam int ESUM_W  = EXP_W + 2;
  localparam int EXP_TOP = (1 << EXP_W) - 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;

  localparam logic [HALF_W-1:0] QNAN_PAT = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    CLS_NORM = 2'd0,
    CLS_ZERO = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } prod_cls_e;

  typedef struct packed {
    logic                      sign;
    prod_cls_e                 cls;
    logic signed [ESUM_W-1:0]  esum;
    logic [PROD_W-1:0]         prod;
  } stage1_t;
endpackage

// File: rtl/hmul2_lane_mult.sv
module hmul2_lane_mult
  import hmul2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [HALF_W-1:0] op_x,
  input  logic [HALF_W-1:0] op_y,
  output stage1_t           st_q
);
  logic [EXP_W-1:0]  ex, ey;
  logic [FRAC_W-1:0] fx, fy;
  logic x_zero, y_zero, x_inf, y_inf, x_nan, y_nan;
  stage1_t st_d;

  assign ex = op_x[HALF_W-2 -: EXP_W];
  assign ey = op_y[HALF_W-2 -: EXP_W];
  assign fx = op_x[FRAC_W-1:0];
  assign fy = op_y[FRAC_W-1:0];

  always_comb begin
    x_zero = (ex == '0);
    y_zero = (ey == '0);
    x_inf  = (ex == EXP_W'(EXP_TOP)) && (fx == '0);
    y_inf  = (ey == EXP_W'(EXP_TOP)) && (fy == '0);
    x_nan  = (ex == EXP_W'(EXP_TOP)) && (fx != '0);
    y_nan  = (ey == EXP_W'(EXP_TOP)) && (fy != '0);
  end

  always_comb begin
    st_d.sign = op_x[HALF_W-1] ^ op_y[HALF_W-1];
    if (x_nan || y_nan || (x_zero && y_inf) || (x_inf && y_zero))
      st_d.cls = CLS_NAN;
    else if (x_inf || y_inf)
      st_d.cls = CLS_INF;
    else if (x_zero || y_zero)
      st_d.cls = CLS_ZERO;
    else
      st_d.cls = CLS_NORM;
    st_d.esum = $signed({2'b00, ex}) + $signed({2'b00, ey}) - ESUM_W'(BIAS);
    st_d.prod = {1'b1, fx} * {1'b1, fy};
  end

  always_ff @(posedge clk) begin
    if (en) begin
      st_q <= st_d;
    end
  end

  a_r8_nan_operand: assert property (@(posedge clk) disable iff (!rst_n)
    en && ((ex == EXP_W'(EXP_TOP) && fx != '0) || (ey == EXP_W'(EXP_TOP) && fy != '0))
    |=> st_q.cls == CLS_NAN);

  a_r9_zero_times_inf: assert property (@(posedge clk) disable iff (!rst_n)
    en && ((ex == '0 && ey == EXP_W'(EXP_TOP) && fy == '0) ||
           (ey == '0 && ex == EXP_W'(EXP_TOP) && fx == '0))
    |=> st_q.cls == CLS_NAN);

  a_r5_flush_operand: assert property (@(posedge clk) disable iff (!rst_n)
    en && (ex == '0 || ey == '0) && ex != EXP_W'(EXP_TOP) && ey != EXP_W'(EXP_TOP)
    |=> st_q.cls == CLS_ZERO);
endmodule

// File: rtl/hmul2_lane_pack.sv
module hmul2_lane_pack
  import hmul2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  stage1_t           st,
  output logic [HALF_W-1:0] res_q
);
  logic signed [ESUM_W-1:0] e_norm;
  logic [FRAC_W-1:0]        frac_n;
  logic [HALF_W-1:0]        res_d;
  logic [HALF_W-2:0]        inf_mag;

  assign inf_mag = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  always_comb begin
    if (st.prod[PROD_W-1]) begin
      e_norm = st.esum + ESUM_W'(1);
      frac_n = st.prod[PROD_W-2 -: FRAC_W];
    end else begin
      e_norm = st.esum;
      frac_n = st.prod[PROD_W-3 -: FRAC_W];
    end
  end

  always_comb begin
    unique case (st.cls)
      CLS_NAN:  res_d = QNAN_PAT;
      CLS_INF:  res_d = {st.sign, inf_mag};
      CLS_ZERO: res_d = {st.sign, {(HALF_W-1){1'b0}}};
      default: begin
        if (e_norm > $signed(ESUM_W'(EXP_TOP - 1)))
          res_d = {st.sign, inf_mag};
        else if (e_norm < $signed(ESUM_W'(1)))
          res_d = {st.sign, {(HALF_W-1){1'b0}}};
        else
          res_d = {st.sign, e_norm[EXP_W-1:0], frac_n};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (en) begin
      res_q <= res_d;
    end
  end

  a_r8_qnan_out: assert property (@(posedge clk) disable iff (!rst_n)
    en && st.cls == CLS_NAN |=> res_q == QNAN_PAT);

  a_r10_inf_out: assert property (@(posedge clk) disable iff (!rst_n)
    en && st.cls == CLS_INF |=> res_q[HALF_W-2:0] == inf_mag && res_q[HALF_W-1] == $past(st.sign));

  a_r3_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
    en && st.cls != CLS_NAN |=> res_q[HALF_W-1] == $past(st.sign));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(res_q));
endmodule

// File: rtl/hmul2_top.sv
module hmul2_top
  import hmul2_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [LANES*HALF_W-1:0]  a,
  input  logic [LANES*HALF_W-1:0]  b,
  output logic                     out_valid,
  output logic [LANES*HALF_W-1:0]  y
);
  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] rst_sync_q;
  logic              rst_int_n;
  logic              v1_q, v1_d;
  logic              v2_q, v2_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_W-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_W-1];

  always_comb begin
    v1_d = in_valid;
    v2_d = v1_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
    end
  end

  assign out_valid = v2_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    stage1_t st_q;

    hmul2_lane_mult u_mult (
      .clk   (clk),
      .rst_n (rst_int_n),
      .en    (in_valid),
      .op_x  (a[g*HALF_W +: HALF_W]),
      .op_y  (b[g*HALF_W +: HALF_W]),
      .st_q  (st_q)
    );

    hmul2_lane_pack u_pack (
      .clk   (clk),
      .rst_n (rst_int_n),
      .en    (v1_q),
      .st    (st_q),
      .res_q (y[g*HALF_W +: HALF_W])
    );
  end

  a_r2_latency_on: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> ##1 out_valid);

  a_r2_latency_off: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> ##1 !out_valid);

  a_r12_y_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !v1_q |=> $stable(y));
endmodule

// File: tb/hmul2_top_tb_top.sv
module hmul2_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic        out_valid;
  logic [31:0] y;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  hmul2_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a(a), .b(b), .out_valid(out_valid), .y(y)
  );

  function automatic logic [15:0] ref_lane(input logic [15:0] x, input logic [15:0] z);
    logic s;
    int ex, ez, fx, fz, p, e, fr;
    bit xnan, znan, xinf, zinf, xz, zz;
    s = x[15] ^ z[15];
    ex = int'(x[14:10]); ez = int'(z[14:10]);
    fx = int'(x[9:0]);   fz = int'(z[9:0]);
    xnan = (ex == 31) && (fx != 0); znan = (ez == 31) && (fz != 0);
    xinf = (ex == 31) && (fx == 0); zinf = (ez == 31) && (fz == 0);
    xz = (ex == 0); zz = (ez == 0);
    if (xnan || znan || (xz && zinf) || (xinf && zz)) return 16'h7E00;
    if (xinf || zinf) return {s, 15'h7C00};
    if (xz || zz) return {s, 15'h0000};
    p = (1024 + fx) * (1024 + fz);
    e = ex + ez - 15;
    if (p >= 2097152) begin
      e = e + 1;
      fr = (p - 2097152) / 2048;
    end else begin
      fr = (p - 1048576) / 1024;
    end
    if (e > 30) return {s, 15'h7C00};
    if (e < 1) return {s, 15'h0000};
    return {s, e[4:0], fr[9:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic drive(input logic [31:0] xa, input logic [31:0] xb,
                       input logic [31:0] expv, input string tag);
    a = xa; b = xb; in_valid = 1'b1;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_ref(input logic [31:0] xa, input logic [31:0] xb, input string tag);
    drive(xa, xb, {ref_lane(xa[31:16], xb[31:16]), ref_lane(xa[15:0], xb[15:0])}, tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && !finished) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected out_valid", y, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(y[15:0] == e[15:0], {t, " lane0"}, {16'h0, y[15:0]}, {16'h0, e[15:0]});
        check(y[31:16] == e[31:16], {t, " lane1"}, {16'h0, y[31:16]}, {16'h0, e[31:16]});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 during reset", {31'h0, out_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 after reset", {31'h0, out_valid}, 32'h0);

    // R2: exact latency of a single pair
    drive(32'h3C00_3C00, 32'h3C00_3C00, 32'h3C00_3C00, "R2 single");
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R2 not early", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    check(out_valid == 1'b1, "R2 on time", {31'h0, out_valid}, 32'h1);
    held = y;
    idle(3);
    // R12: output holds with no new result
    check(out_valid == 1'b0, "R12 idle valid", {31'h0, out_valid}, 32'h0);
    check(y == held, "R12 hold", y, held);

    // R3 normal products, R4 normalisation shift
    drive(32'hC000_3C00, 32'h4200_3C00, 32'hC600_3C00, "R3 basic");
    drive(32'h3FFF_3E00, 32'h3FFF_3E00, {ref_lane(16'h3FFF, 16'h3FFF), 16'h4080}, "R4 shift");
    drive(32'h3555_4248, 32'hB555_C0A3, {ref_lane(16'h3555, 16'hB555), ref_lane(16'h4248, 16'hC0A3)}, "R3 truncate");
    // R5 subnormal flush
    drive(32'h83FF_0001, 32'h3C00_3C00, 32'h8000_0000, "R5 flush");
    // R6 overflow
    drive(32'h7800_7BFF, 32'hF800_7BFF, 32'hFC00_7C00, "R6 overflow");
    drive(32'h7BFF_7800, 32'h4000_3C00, 32'h7C00_7800, "R6 edge");
    // R7 underflow and lower edge
    drive(32'h8400_0400, 32'h3800_0400, 32'h8000_0000, "R7 underflow");
    drive(32'h3C00_0400, 32'h3800_3C00, 32'h3800_0400, "R7 edge");
    // R8 NaN
    drive(32'hFE00_7C01, 32'h0000_3C00, 32'h7E00_7E00, "R8 nan");
    // R9 zero times infinity
    drive(32'hFC00_0000, 32'h8000_7C00, 32'h7E00_7E00, "R9 zero_inf");
    drive(32'h7C00_0001, 32'h0200_7C00, 32'h7E00_7E00, "R9 flushed_inf");
    // R10 infinity times finite
    drive(32'hFC00_7C00, 32'hFC00_C000, 32'h7C00_FC00, "R10 inf");
    // R11 lane independence
    drive(32'h7C01_4000, 32'h3C00_4000, 32'h7E00_4400, "R11 lane0");
    drive(32'h4000_7C01, 32'h4000_3C00, 32'h4400_7E00, "R11 lane1");
    idle(4);
    check(exp_q.size() == 0, "R2 ordering drained", exp_q.size(), 32'h0);

    // random streams with gaps
    for (int i = 0; i < 300; i++) begin
      drive_ref($urandom, $urandom, "R3 random");
      if ((i % 7) == 3) idle(1 + (i % 3));
    end
    idle(4);
    check(exp_q.size() == 0, "R2 stream drained", exp_q.size(), 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule